// File: doc/BRIEF.md
# Programmable Ethernet Status LED Driver

This block drives two active-low indicator lamps from the status of a network port: whether the link is up, whether it runs at 100 Mb/s, and single-cycle activity pulses. A 2-bit mode input selects what each lamp means. In the combined mode, the first lamp shows link and activity together and the second shows speed. In the split mode, the first lamp shows link alone and the second shows activity alone. The two remaining codes are reserved, and both lamps stay dark.

Activity is made visible in two steps. Every accepted pulse reloads a stretch timer, so even one short frame keeps the activity indication alive for a fixed number of cycles. While the timer runs, a toggle generator alternates the lamp between on and off with a programmable half-period. Activity is ignored while the link is down. Both lamp outputs are registered, so each output reflects the inputs one clock edge earlier.

Top module: `eth_status_led`

## Requirements
- R1: While `rst` is high at a clock edge, both `led0_n` and `led1_n` are high (off) after that edge.
- R2: Mode code 2'b00, with no running activity: `led0_n` is high when `link_up` is 0 and low when `link_up` is 1.
- R3: Mode code 2'b00: `led1_n` equals the inverse of `speed_100` (low = 100 Mb/s, high = 10 Mb/s), whatever the link state.
- R4: Mode code 2'b01: `led0_n` equals the inverse of `link_up`, and activity pulses do not change it.
- R5: Mode code 2'b01: `led1_n` is high with no running activity and blinks while activity runs.
- R6: Mode codes 2'b10 and 2'b11: both outputs stay high, even with link up, 100 Mb/s and activity pulses.
- R7: Blink timing: an activity pulse with the link up is sampled at edge E0. After edge Ek, for k = 1..STRETCH_CYCLES, the blinking lamp is low (on) when ((k-1)/BLINK_HALF) is even and high when it is odd. From k = STRETCH_CYCLES+1 the lamp returns to its idle level (mode 00 lamp 0: low; mode 01 lamp 1: high).
- R8: A new pulse while activity runs reloads the stretch timer, and the blink phase continues without restarting. A pulse at E5 after one at E0 keeps the blink going through k = 5+STRETCH_CYCLES.
- R9: While `link_up` is 0, activity pulses are ignored, and a link drop ends any running activity. Once the link returns, no blinking is left over from before the drop.
- R10: Every output is registered: a change on `link_up`, `speed_100` or `led_mode` sampled at an edge appears on the outputs right after that same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| link_up | input | 1 | Link established |
| speed_100 | input | 1 | 1 = 100 Mb/s, 0 = 10 Mb/s |
| act_pulse | input | 1 | One-cycle activity event |
| led_mode | input | 2 | Lamp function select |
| led0_n | output | 1 | Lamp 0, active low |
| led1_n | output | 1 | Lamp 1, active low |

## Verification
Static inputs (link, speed, mode) take effect at the first clock edge that samples them. The bench therefore changes these inputs on a falling edge and reads the lamps on the falling edge that follows the next rising edge. For activity, edge E0 is the one that samples the pulse. After each later edge Ek, the bench compares the lamp with the phase ((k-1)/BLINK_HALF) mod 2, counting k itself. It also checks the switch back to the idle level at k = STRETCH_CYCLES+1, or at the reloaded limit when a second pulse comes. The bench uses short parameter values (BLINK_HALF = 3, STRETCH_CYCLES = 10), so that every phase edge and the end of the stretch fall inside a short window.

// File: rtl/eth_led_pkg.sv
package eth_led_pkg;

    typedef enum logic [1:0] {
        MODE_COMBINED = 2'b00,
        MODE_SPLIT    = 2'b01,
        MODE_RSV_A    = 2'b10,
        MODE_RSV_B    = 2'b11
    } led_mode_e;

    typedef struct packed {
        logic link;
        logic fast;
        logic busy;
        logic dark_phase;
    } port_state_t;

    typedef struct packed {
        logic lamp0_n;
        logic lamp1_n;
    } lamp_pair_t;

    localparam lamp_pair_t LAMPS_OFF = '{lamp0_n: 1'b1, lamp1_n: 1'b1};

    function automatic lamp_pair_t map_lamps(led_mode_e mode, port_state_t st);
        lamp_pair_t r;
        logic act_level;
        act_level = st.busy ? st.dark_phase : 1'b0;
        r = LAMPS_OFF;
        case (mode)
            MODE_COMBINED: begin
                r.lamp0_n = st.link ? act_level : 1'b1;
                r.lamp1_n = ~st.fast;
            end
            MODE_SPLIT: begin
                r.lamp0_n = ~st.link;
                r.lamp1_n = st.busy ? st.dark_phase : 1'b1;
            end
            default: r = LAMPS_OFF;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/act_stretch.sv
module act_stretch #(
    parameter int STRETCH_CYCLES = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic link_up,
    input  logic act_pulse,
    output logic busy
);
    localparam int CW = $clog2(STRETCH_CYCLES + 1);
    localparam logic [CW-1:0] LOAD = CW'(STRETCH_CYCLES);

    logic [CW-1:0] remain_q;

    always_ff @(posedge clk) begin
        if (rst || !link_up) begin
            remain_q <= '0;
        end else if (act_pulse) begin
            remain_q <= LOAD;
        end else if (remain_q != '0) begin
            remain_q <= remain_q - 1'b1;
        end
    end

    assign busy = (remain_q != '0);

    // R8
    reload_chk: assert property (@(posedge clk) disable iff (rst)
        (act_pulse && link_up) |=> busy);

    // R9
    link_drop_chk: assert property (@(posedge clk) disable iff (rst)
        !link_up |=> !busy);

endmodule

// File: rtl/blink_gen.sv
module blink_gen #(
    parameter int BLINK_HALF = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic busy,
    output logic dark_phase
);
    localparam int PW = (BLINK_HALF > 1) ? $clog2(BLINK_HALF) : 1;
    localparam logic [PW-1:0] LAST = PW'(BLINK_HALF - 1);

    logic [PW-1:0] tick_q;
    logic          dark_q;

    always_ff @(posedge clk) begin
        if (rst || !busy) begin
            tick_q <= '0;
            dark_q <= 1'b0;
        end else if (tick_q == LAST) begin
            tick_q <= '0;
            dark_q <= ~dark_q;
        end else begin
            tick_q <= tick_q + 1'b1;
        end
    end

    assign dark_phase = dark_q;

    // R7
    idle_phase_chk: assert property (@(posedge clk) disable iff (rst)
        !busy |=> !dark_phase);

    // R7
    phase_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && tick_q != LAST) |=> $stable(dark_phase));

endmodule

// File: rtl/lamp_encode.sv
module lamp_encode
    import eth_led_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  led_mode_e   mode,
    input  port_state_t st,
    output lamp_pair_t  lamps
);
    always_ff @(posedge clk) begin
        if (rst) begin
            lamps <= LAMPS_OFF;
        end else begin
            lamps <= map_lamps(mode, st);
        end
    end

    // R6
    reserved_dark_chk: assert property (@(posedge clk) disable iff (rst)
        (mode == MODE_RSV_A || mode == MODE_RSV_B) |=> (lamps == LAMPS_OFF));

    // R3
    speed_lamp_chk: assert property (@(posedge clk) disable iff (rst)
        (mode == MODE_COMBINED) |=> (lamps.lamp1_n == !$past(st.fast)));

    // R4
    link_only_chk: assert property (@(posedge clk) disable iff (rst)
        (mode == MODE_SPLIT) |=> (lamps.lamp0_n == !$past(st.link)));

endmodule

// File: rtl/eth_status_led.sv
module eth_status_led
    import eth_led_pkg::*;
#(
    parameter int BLINK_HALF     = 2_500_000,
    parameter int STRETCH_CYCLES = 5_000_000
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       link_up,
    input  logic       speed_100,
    input  logic       act_pulse,
    input  logic [1:0] led_mode,
    output logic       led0_n,
    output logic       led1_n
);
    logic        busy;
    logic        dark_phase;
    port_state_t st;
    lamp_pair_t  lamps;

    act_stretch #(.STRETCH_CYCLES(STRETCH_CYCLES)) stretch_i (
        .clk       (clk),
        .rst       (rst),
        .link_up   (link_up),
        .act_pulse (act_pulse),
        .busy      (busy)
    );

    blink_gen #(.BLINK_HALF(BLINK_HALF)) blink_i (
        .clk        (clk),
        .rst        (rst),
        .busy       (busy),
        .dark_phase (dark_phase)
    );

    always_comb begin
        st.link       = link_up;
        st.fast       = speed_100;
        st.busy       = busy;
        st.dark_phase = dark_phase;
    end

    lamp_encode encode_i (
        .clk   (clk),
        .rst   (rst),
        .mode  (led_mode_e'(led_mode)),
        .st    (st),
        .lamps (lamps)
    );

    assign led0_n = lamps.lamp0_n;
    assign led1_n = lamps.lamp1_n;

    // R1
    reset_dark_chk: assert property (@(posedge clk)
        rst |=> (led0_n && led1_n));

    // R2
    no_link_dark_chk: assert property (@(posedge clk) disable iff (rst)
        !link_up |=> led0_n);

endmodule

// File: tb/eth_status_led_tb_top.sv
module eth_status_led_tb_top;

    localparam int HALF = 3;
    localparam int STR  = 10;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic link_up = 1'b0;
    logic speed_100 = 1'b0;
    logic act_pulse = 1'b0;
    logic [1:0] led_mode = 2'b00;
    logic led0_n, led1_n;

    int checks = 0;
    int fails  = 0;

    always #2 clk = ~clk;

    eth_status_led #(.BLINK_HALF(HALF), .STRETCH_CYCLES(STR)) dut_i (
        .clk(clk), .rst(rst), .link_up(link_up), .speed_100(speed_100),
        .act_pulse(act_pulse), .led_mode(led_mode),
        .led0_n(led0_n), .led1_n(led1_n)
    );

    // {mode[1:0], link, speed, exp led0_n, exp led1_n}
    localparam int NV = 8;
    localparam logic [5:0] VEC [NV] = '{
        6'b00_0_0_1_1, 6'b00_1_0_0_1, 6'b00_1_1_0_0, 6'b00_0_1_1_0,
        6'b01_0_1_1_1, 6'b01_1_1_0_1, 6'b10_1_1_1_1, 6'b11_1_0_1_1
    };

    task automatic check(input string tag, input logic got, input logic exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %b expected %b", tag, got, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic pulse();
        act_pulse = 1'b1;
        step();
        act_pulse = 1'b0;
    endtask

    function automatic logic blink_level(int k);
        return logic'(((k - 1) / HALF) % 2);
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: got timeout expected finish");
        $display("%0d/%0d checks passed", checks - fails + 1, checks + 1);
        $finish;
    end

    initial begin
        // R1: lamps dark under reset even with link up at 100 Mb/s
        link_up = 1'b1; speed_100 = 1'b1;
        repeat (3) step();
        check("R1 led0_n in reset", led0_n, 1'b1);
        check("R1 led1_n in reset", led1_n, 1'b1);
        rst = 1'b0;
        step();

        // static table: R2 R3 R4 R6 R10, one edge latency
        for (int i = 0; i < NV; i++) begin
            led_mode  = VEC[i][5:4];
            link_up   = VEC[i][3];
            speed_100 = VEC[i][2];
            step();
            check(VEC[i][5] ? "R6 led0_n" : (VEC[i][4] ? "R4 led0_n" : "R2 led0_n R10"),
                  led0_n, VEC[i][1]);
            check(VEC[i][5] ? "R6 led1_n" : (VEC[i][4] ? "R5 led1_n idle" : "R3 led1_n R10"),
                  led1_n, VEC[i][0]);
        end

        // R5 R7: split mode, activity on lamp 1; R4: lamp 0 unaffected
        led_mode = 2'b01; link_up = 1'b1; speed_100 = 1'b0;
        step();
        pulse();
        for (int k = 1; k <= STR + 2; k++) begin
            step();
            check("R7 R5 led1_n blink", led1_n, (k <= STR) ? blink_level(k) : 1'b1);
            check("R4 led0_n ignores activity", led0_n, 1'b0);
        end

        // R2 R7: combined mode, lamp 0 blinks then returns on
        led_mode = 2'b00; speed_100 = 1'b1;
        step();
        pulse();
        for (int k = 1; k <= STR + 2; k++) begin
            step();
            check("R7 R2 led0_n blink", led0_n, (k <= STR) ? blink_level(k) : 1'b0);
            check("R3 led1_n speed", led1_n, 1'b0);
        end

        // R8: second pulse at E5 extends to k = 5+STR
        led_mode = 2'b01;
        step();
        pulse();
        for (int k = 1; k <= 4; k++) step();
        pulse();
        for (int k = 6; k <= STR + 6; k++) begin
            step();
            check("R8 led1_n retrigger", led1_n, (k <= STR + 5) ? blink_level(k) : 1'b1);
        end

        // R6: reserved modes ignore activity
        led_mode = 2'b10;
        step();
        pulse();
        for (int k = 1; k <= 6; k++) begin
            step();
            check("R6 led0_n reserved", led0_n, 1'b1);
            check("R6 led1_n reserved", led1_n, 1'b1);
            if (k == 3) led_mode = 2'b11;
        end

        // R9: pulses ignored with link down
        led_mode = 2'b01; link_up = 1'b0;
        step();
        pulse();
        for (int k = 1; k <= 4; k++) begin
            step();
            check("R9 led1_n no link", led1_n, 1'b1);
        end

        // R9: link drop ends running activity
        link_up = 1'b1;
        step();
        pulse();
        step(); step();
        link_up = 1'b0;
        step();
        for (int k = 0; k < 3; k++) begin
            step();
            check("R9 led1_n after drop", led1_n, 1'b1);
        end
        link_up = 1'b1;
        for (int k = 0; k < 3; k++) begin
            step();
            check("R9 led1_n after relink", led1_n, 1'b1);
            check("R4 led0_n relink", led0_n, 1'b0);
        end

        // R1: reset mid-run darkens lamps
        led_mode = 2'b00; speed_100 = 1'b1;
        step();
        check("R3 led1_n before reset", led1_n, 1'b0);
        rst = 1'b1;
        step();
        check("R1 led0_n mid reset", led0_n, 1'b1);
        check("R1 led1_n mid reset", led1_n, 1'b1);
        rst = 1'b0;
        step();
        check("R10 led1_n after release", led1_n, 1'b0);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule